// File: doc/BRIEF.md
# Multi-Hop Link Training Sequencer

This block runs the top level of link training for a serial display link that may pass through a chain of retimers before it reaches the final sink. When `start` is pulsed it picks the repeater operating mode from a set of capability and policy inputs. It then issues one request to write the link configuration (rate, lane count, spread) to the sink. After that it drives the clock-recovery and equalization phase controllers once per hop, using start and done handshakes.

In non-transparent mode every retimer is trained on its own. The hops run from the highest repeater index down to index 1, and the sink (hop 0) comes last. A repeater is always told when its hop has ended, whether the hop passed or failed. Between successful repeater hops, the lane drive settings are cleared. In the other modes only the sink is trained. The first failing phase result ends the run. The final result code is held on a registered output, together with a done flag, until the next start.

The phase controllers are outside this block. They report a 3-bit result code, where 0 means success and any non-zero value is a failure code that is passed through unchanged.

Top module: `link_train_seq`

## Requirements
- R1: Mode selection, with `mode` encoded 0 = no repeater, 1 = transparent, 2 = non-transparent, and latched at `start`. If `rpt_present` is 0 the mode is 0. Otherwise, if `fw_aware` is 1, the mode is 2 when `fw_force_nt` is 1 and 1 when it is 0. Otherwise the mode is 2 when both `allow_nt` and `ext_timeout_ok` are 1, and 0 in every other case. `mode` is never 3.
- R2: The repeater count is taken from `rpt_cnt_code`: 0x80 means 1, 0x40 means 2, 0x20 means 3, and so on down to 0x01, which means 8. Any other code means zero repeaters. The count is used only in mode 2.
- R3: After an accepted `start`, `cfg_write` pulses for one cycle. This pulse comes before any phase request and is followed directly by the first `cr_start`.
- R4: Hops are trained in the order N, N-1, …, 1, 0, where N is the repeater count in mode 2 and 0 in the other modes. Each hop runs `cr_start` and then `eq_start`, and `hop_idx` shows the hop during every request and notice.
- R5: If clock recovery fails at a repeater hop, the block pulses `hop_end` for that hop, requests no equalization, and finishes with the clock-recovery result.
- R6: After equalization at a repeater hop, the block pulses `hop_end` whatever the result. It finishes with that result if the result is non-zero.
- R7: After a successful repeater hop, `lane_clr` pulses once. It comes after that hop's `hop_end` and directly before the `cr_start` of the next lower hop.
- R8: The sink (hop 0) is trained only if every repeater hop succeeded. It never gets `hop_end`, and it gets `eq_start` only if its clock recovery returned 0.
- R9: `done` rises when the run ends. `result` is 0 on full success and otherwise the failing phase code. Both are held until the next accepted `start`, and `done` is low in the cycle after that start.
- R10: A `start` that arrives while a run is in progress is ignored.
- R11: At most one of `cfg_write`, `cr_start`, `eq_start`, `hop_end` and `lane_clr` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a training run (pulse) |
| rpt_present | input | 1 | At least one retimer detected |
| rpt_cnt_code | input | 8 | Raw repeater count code |
| fw_aware | input | 1 | Firmware is repeater-aware |
| fw_force_nt | input | 1 | Firmware forces non-transparent mode |
| allow_nt | input | 1 | Policy allows non-transparent mode |
| ext_timeout_ok | input | 1 | Extended side-channel timeout supported |
| cfg_write | output | 1 | Write link configuration to the sink (pulse) |
| cr_start | output | 1 | Request a clock-recovery phase (pulse) |
| cr_done | input | 1 | Clock-recovery phase finished (pulse) |
| cr_res | input | 3 | Clock-recovery result, 0 = pass |
| eq_start | output | 1 | Request an equalization phase (pulse) |
| eq_done | input | 1 | Equalization phase finished (pulse) |
| eq_res | input | 3 | Equalization result, 0 = pass |
| hop_idx | output | 4 | Hop being trained, 0 = sink |
| hop_end | output | 1 | Training-done notice to repeater `hop_idx` (pulse) |
| lane_clr | output | 1 | Clear lane drive settings of all lanes (pulse) |
| mode | output | 2 | Selected repeater mode |
| done | output | 1 | Run finished, held until next start |
| result | output | 3 | Final result code |

## Verification
The assertions assume that each phase controller pulses its done line exactly once for each request, that it does so only while that request is outstanding, and that the result code is valid in the done cycle. The bench's phase stubs meet these conditions. They answer each request after a fixed latency, with a scripted result chosen by hop index, and they never raise done without a request. The assertions also assume `start` is a pulse. The bench drives it for one cycle only, and it deliberately repeats it in the middle of a run to exercise the ignore rule.

// File: rtl/lts_pkg.sv
// Shared types for the multi-hop link training sequencer.
// Assumes a 3-bit phase result where zero means pass.
package lts_pkg;
    typedef enum logic [1:0] {
        MODE_NONE = 2'd0,
        MODE_TRANSP = 2'd1,
        MODE_NONTRANSP = 2'd2
    } lts_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CFG,
        ST_CR_GO,
        ST_CR_WAIT,
        ST_EQ_GO,
        ST_EQ_WAIT,
        ST_NOTIFY,
        ST_CLEAR,
        ST_FINISH
    } lts_state_e;
endpackage

// File: rtl/lts_mode_sel.sv
// Repeater mode decision. Purely combinational: applies the fixed priority
// presence > firmware-aware (force picks non-transparent) > policy+timeout.
// Assumes inputs are stable when the sequencer latches the output at start.
module lts_mode_sel
    import lts_pkg::*;
(
    input  logic      rpt_present,
    input  logic      fw_aware,
    input  logic      fw_force_nt,
    input  logic      allow_nt,
    input  logic      ext_timeout_ok,
    output lts_mode_e mode_sel
);
    // Priority chain for the mode choice
    always_comb begin
        if (!rpt_present) begin
            mode_sel = MODE_NONE;
        end else if (fw_aware) begin
            mode_sel = fw_force_nt ? MODE_NONTRANSP : MODE_TRANSP;
        end else if (allow_nt && ext_timeout_ok) begin
            mode_sel = MODE_NONTRANSP;
        end else begin
            mode_sel = MODE_NONE;
        end
    end
endmodule

// File: rtl/lts_hop_decode.sv
// Decodes the raw repeater count code. A single set bit at position
// CODE_W-1-k means k+1 repeaters; any other pattern means zero.
// Assumes HOP_W can hold CODE_W.
module lts_hop_decode #(
    parameter int CODE_W = 8,
    parameter int HOP_W  = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic [HOP_W-1:0]  count
);
    logic [CODE_W-1:0] match;

    // One comparator per legal code value
    for (genvar k = 0; k < CODE_W; k++) begin : g_match
        localparam logic [CODE_W-1:0] PAT = CODE_W'(1) << (CODE_W - 1 - k);
        assign match[k] = (code == PAT);
    end

    // Encode the matching position into a count; no match leaves zero
    always_comb begin
        count = '0;
        for (int k = 0; k < CODE_W; k++) begin
            if (match[k]) count = HOP_W'(k + 1);
        end
    end
endmodule

// File: rtl/lts_fsm.sv
// Hop sequencing state machine. Latches mode and starting hop at start,
// issues the configuration write, then one clock-recovery and one
// equalization request per hop, notifies repeaters when each hop ends and
// clears lane settings between successful repeater hops.
// Assumes done pulses from the phase controllers arrive only while the
// matching request is outstanding; stray done pulses are ignored.
module lts_fsm
    import lts_pkg::*;
#(
    parameter int HOP_W = 4,
    parameter int RES_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  lts_mode_e        mode_in,
    input  logic [HOP_W-1:0] rpt_count,
    input  logic             cr_done,
    input  logic [RES_W-1:0] cr_res,
    input  logic             eq_done,
    input  logic [RES_W-1:0] eq_res,
    output logic             cfg_write,
    output logic             cr_start,
    output logic             eq_start,
    output logic             hop_end,
    output logic             lane_clr,
    output logic [HOP_W-1:0] hop_idx,
    output lts_mode_e        mode_out,
    output logic             done,
    output logic [RES_W-1:0] result
);
    lts_state_e       state_q;
    logic [HOP_W-1:0] hop_q;
    logic [RES_W-1:0] res_q;
    logic [RES_W-1:0] result_q;
    lts_mode_e        mode_q;
    logic             done_q;
    logic             at_sink;

    assign at_sink = (hop_q == '0);

    // State, hop counter, latched mode and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            hop_q    <= '0;
            res_q    <= '0;
            result_q <= '0;
            mode_q   <= MODE_NONE;
            done_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q  <= mode_in;
                        hop_q   <= (mode_in == MODE_NONTRANSP) ? rpt_count : '0;
                        res_q   <= '0;
                        done_q  <= 1'b0;
                        state_q <= ST_CFG;
                    end
                end
                ST_CFG:   state_q <= ST_CR_GO;
                ST_CR_GO: state_q <= ST_CR_WAIT;
                ST_CR_WAIT: begin
                    if (cr_done) begin
                        res_q <= cr_res;
                        if (cr_res == '0) state_q <= ST_EQ_GO;
                        else if (!at_sink) state_q <= ST_NOTIFY;
                        else state_q <= ST_FINISH;
                    end
                end
                ST_EQ_GO: state_q <= ST_EQ_WAIT;
                ST_EQ_WAIT: begin
                    if (eq_done) begin
                        res_q   <= eq_res;
                        state_q <= at_sink ? ST_FINISH : ST_NOTIFY;
                    end
                end
                ST_NOTIFY: state_q <= (res_q != '0) ? ST_FINISH : ST_CLEAR;
                ST_CLEAR: begin
                    hop_q   <= hop_q - HOP_W'(1);
                    state_q <= ST_CR_GO;
                end
                ST_FINISH: begin
                    result_q <= res_q;
                    done_q   <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Moore action pulses decoded from the state
    always_comb begin
        cfg_write = (state_q == ST_CFG);
        cr_start  = (state_q == ST_CR_GO);
        eq_start  = (state_q == ST_EQ_GO);
        hop_end   = (state_q == ST_NOTIFY);
        lane_clr  = (state_q == ST_CLEAR);
    end

    assign hop_idx  = hop_q;
    assign mode_out = mode_q;
    assign done     = done_q;
    assign result   = result_q;
endmodule

// File: rtl/link_train_seq.sv
// Multi-hop link training sequencer, top level. Chooses the repeater mode,
// decodes the repeater count and runs the hop state machine that drives the
// external clock-recovery and equalization phase controllers.
// Assumes a single clock domain with phase controllers in it.
module link_train_seq
    import lts_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int RES_W  = 3,
    parameter int HOP_W  = $clog2(CODE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rpt_present,
    input  logic [CODE_W-1:0] rpt_cnt_code,
    input  logic              fw_aware,
    input  logic              fw_force_nt,
    input  logic              allow_nt,
    input  logic              ext_timeout_ok,
    output logic              cfg_write,
    output logic              cr_start,
    input  logic              cr_done,
    input  logic [RES_W-1:0]  cr_res,
    output logic              eq_start,
    input  logic              eq_done,
    input  logic [RES_W-1:0]  eq_res,
    output logic [HOP_W-1:0]  hop_idx,
    output logic              hop_end,
    output logic              lane_clr,
    output logic [1:0]        mode,
    output logic              done,
    output logic [RES_W-1:0]  result
);
    lts_mode_e        mode_pick;
    lts_mode_e        mode_held;
    logic [HOP_W-1:0] rpt_count;

    lts_mode_sel u_mode_sel (
        .rpt_present   (rpt_present),
        .fw_aware      (fw_aware),
        .fw_force_nt   (fw_force_nt),
        .allow_nt      (allow_nt),
        .ext_timeout_ok(ext_timeout_ok),
        .mode_sel      (mode_pick)
    );

    lts_hop_decode #(.CODE_W(CODE_W), .HOP_W(HOP_W)) u_hop_decode (
        .code (rpt_cnt_code),
        .count(rpt_count)
    );

    lts_fsm #(.HOP_W(HOP_W), .RES_W(RES_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode_in  (mode_pick),
        .rpt_count(rpt_count),
        .cr_done  (cr_done),
        .cr_res   (cr_res),
        .eq_done  (eq_done),
        .eq_res   (eq_res),
        .cfg_write(cfg_write),
        .cr_start (cr_start),
        .eq_start (eq_start),
        .hop_end  (hop_end),
        .lane_clr (lane_clr),
        .hop_idx  (hop_idx),
        .mode_out (mode_held),
        .done     (done),
        .result   (result)
    );

    assign mode = mode_held;
endmodule

// File: rtl/link_train_seq_chk.sv
// Protocol checker for link_train_seq, bound to every instance.
// Assumes phase done pulses only follow a request.
module link_train_seq_chk #(
    parameter int RES_W = 3,
    parameter int HOP_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             cfg_write,
    input logic             cr_start,
    input logic             eq_start,
    input logic             hop_end,
    input logic             lane_clr,
    input logic [HOP_W-1:0] hop_idx,
    input logic [1:0]       mode,
    input logic             done,
    input logic [RES_W-1:0] result
);
    localparam logic [HOP_W-1:0] HOP_ONE = 1;

    // R11
    onehot_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_write, cr_start, eq_start, hop_end, lane_clr}));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(result)));

    // R8
    sink_no_notice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hop_end |-> (hop_idx != '0));

    // R7
    clear_after_notice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_clr |-> $past(hop_end));

    // R7
    clear_then_lower_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_clr |=> (cr_start && (hop_idx == $past(hop_idx) - HOP_ONE)));

    // R3
    cfg_before_cr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_write |=> cr_start);

    // R1
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'd3);
endmodule

bind link_train_seq link_train_seq_chk #(.RES_W(RES_W), .HOP_W(HOP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cfg_write(cfg_write),
    .cr_start (cr_start),
    .eq_start (eq_start),
    .hop_end  (hop_end),
    .lane_clr (lane_clr),
    .hop_idx  (hop_idx),
    .mode     (mode),
    .done     (done),
    .result   (result)
);

// File: tb/link_train_seq_tb.sv
// Bench for link_train_seq: phase stubs with scripted results, an expected
// action trace built from the requirements, compared on every clock.
module link_train_seq_tb;
    localparam int EV_CFG = 1, EV_CR = 2, EV_EQ = 3, EV_END = 4, EV_CLR = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       rpt_present = 1'b0;
    logic [7:0] rpt_cnt_code = 8'h00;
    logic       fw_aware = 1'b0, fw_force_nt = 1'b0, allow_nt = 1'b0, ext_timeout_ok = 1'b0;
    logic       cfg_write, cr_start, eq_start, hop_end, lane_clr;
    logic       cr_done = 1'b0, eq_done = 1'b0;
    logic [2:0] cr_res = 3'd0, eq_res = 3'd0;
    logic [3:0] hop_idx;
    logic [1:0] mode;
    logic       done;
    logic [2:0] result;

    int vectors = 0;
    int errors = 0;
    int cyc = 0;
    int exp_q[$];
    int cr_scr[9];
    int eq_scr[9];
    int cr_cnt = 0, eq_cnt = 0, cr_hop = 0, eq_hop = 0;
    bit await_done = 0;
    int exp_res = 0, exp_mode = 0;
    string cur_req = "R4";

    always #2.5 clk = ~clk;

    link_train_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rpt_present(rpt_present),
        .rpt_cnt_code(rpt_cnt_code), .fw_aware(fw_aware), .fw_force_nt(fw_force_nt),
        .allow_nt(allow_nt), .ext_timeout_ok(ext_timeout_ok), .cfg_write(cfg_write),
        .cr_start(cr_start), .cr_done(cr_done), .cr_res(cr_res), .eq_start(eq_start),
        .eq_done(eq_done), .eq_res(eq_res), .hop_idx(hop_idx), .hop_end(hop_end),
        .lane_clr(lane_clr), .mode(mode), .done(done), .result(result)
    );

    task automatic check(input string req, input int act, input int expv, input string what);
        vectors++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // R1 priority rule written from the requirement
    function automatic int exp_mode_fn(bit pres, bit aware, bit force_nt, bit allow, bit ext);
        if (!pres) return 0;
        if (aware) return force_nt ? 2 : 1;
        if (allow && ext) return 2;
        return 0;
    endfunction

    // R2 count code table
    function automatic int exp_count_fn(logic [7:0] code);
        for (int k = 0; k < 8; k++) if (code == (8'h80 >> k)) return k + 1;
        return 0;
    endfunction

    // Build the expected action trace (R3..R8) and final result (R9)
    task automatic build_trace(input int md, input int n);
        int first;
        exp_q.delete();
        exp_q.push_back(EV_CFG * 16);
        first = (md == 2) ? n : 0;
        for (int h = first; h >= 0; h--) begin
            exp_q.push_back(EV_CR * 16 + h);
            if (cr_scr[h] != 0) begin
                if (h != 0) exp_q.push_back(EV_END * 16 + h);
                exp_res = cr_scr[h];
                return;
            end
            exp_q.push_back(EV_EQ * 16 + h);
            if (h != 0) exp_q.push_back(EV_END * 16 + h);
            if (eq_scr[h] != 0) begin
                exp_res = eq_scr[h];
                return;
            end
            if (h != 0) exp_q.push_back(EV_CLR * 16 + h);
        end
        exp_res = 0;
    endtask

    // Per-negedge: phase stubs and trace comparison
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            cr_done = 1'b0;
            eq_done = 1'b0;
            if (cr_cnt > 0) begin
                cr_cnt--;
                if (cr_cnt == 0) begin cr_done = 1'b1; cr_res = 3'(cr_scr[cr_hop]); end
            end
            if (eq_cnt > 0) begin
                eq_cnt--;
                if (eq_cnt == 0) begin eq_done = 1'b1; eq_res = 3'(eq_scr[eq_hop]); end
            end
            if (cr_start) begin cr_cnt = 3; cr_hop = int'(hop_idx); end
            if (eq_start) begin eq_cnt = 2; eq_hop = int'(hop_idx); end
            if (rst_n && (cfg_write || cr_start || eq_start || hop_end || lane_clr)) begin
                int ev;
                ev = cfg_write ? EV_CFG * 16 :
                     cr_start  ? EV_CR * 16 + int'(hop_idx) :
                     eq_start  ? EV_EQ * 16 + int'(hop_idx) :
                     hop_end   ? EV_END * 16 + int'(hop_idx) :
                                 EV_CLR * 16 + int'(hop_idx);
                // R11 one action per cycle
                check("R11", $countones({cfg_write, cr_start, eq_start, hop_end, lane_clr}), 1, "actions in cycle");
                if (exp_q.size() == 0) check(cur_req, ev, 0, "unexpected action");
                else check(cur_req, ev, exp_q.pop_front(), "action/hop");
            end
            if (await_done && done) begin
                await_done = 0;
                check("R9", int'(result), exp_res, "final result");
                check("R1", int'(mode), exp_mode, "mode");
                check(cur_req, exp_q.size(), 0, "actions left");
            end
        end
    end

    // Watchdog
    initial begin
        wait (cyc > 150000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    task automatic run(input string req, input bit pres, input logic [7:0] code,
                       input bit aware, input bit force_nt, input bit allow, input bit ext,
                       input bit restart_mid);
        int md;
        int waited;
        cur_req = req;
        @(negedge clk);
        rpt_present = pres; rpt_cnt_code = code; fw_aware = aware;
        fw_force_nt = force_nt; allow_nt = allow; ext_timeout_ok = ext;
        md = exp_mode_fn(pres, aware, force_nt, allow, ext);
        exp_mode = md;
        build_trace(md, exp_count_fn(code));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R9 done drops after an accepted start
        check("R9", int'(done), 0, "done after start");
        await_done = 1;
        if (restart_mid) begin
            repeat (5) @(negedge clk);
            // R10 retrigger with different inputs must change nothing
            rpt_cnt_code = 8'h01; fw_aware = 1'b1; fw_force_nt = 1'b1; rpt_present = 1'b1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (await_done && waited < 2000) begin @(negedge clk); waited++; end
        if (await_done) begin
            await_done = 0;
            check(req, 0, 1, "run timeout");
        end
        // R9 result held while idle
        repeat (6) @(negedge clk);
        check("R9", int'(done), 1, "done held");
        check("R9", int'(result), exp_res, "result held");
    endtask

    task automatic clear_scripts();
        for (int h = 0; h < 9; h++) begin cr_scr[h] = 0; eq_scr[h] = 0; end
    endtask

    initial begin
        clear_scripts();
        repeat (4) @(negedge clk);
        // R9 reset state
        check("R9", int'(done), 0, "reset done");
        check("R9", int'(result), 0, "reset result");
        check("R1", int'(mode), 0, "reset mode");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run("R8", 1'b0, 8'h20, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);          // no repeater
        run("R4", 1'b1, 8'h20, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);          // policy NT, 3 hops
        run("R4", 1'b1, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);          // forced NT, 8 hops
        run("R1", 1'b1, 8'h80, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);          // transparent
        run("R2", 1'b1, 8'h30, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);          // invalid code
        run("R1", 1'b1, 8'h40, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);          // no ext timeout
        run("R1", 1'b0, 8'h40, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);          // absent overrides
        clear_scripts(); cr_scr[2] = 1;
        run("R5", 1'b1, 8'h40, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);          // CR fail at top hop
        clear_scripts(); eq_scr[2] = 3;
        run("R6", 1'b1, 8'h20, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);          // EQ fail mid chain
        clear_scripts(); cr_scr[0] = 2;
        run("R8", 1'b1, 8'h40, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);          // sink CR fail
        clear_scripts(); eq_scr[0] = 5;
        run("R7", 1'b1, 8'h40, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);          // sink EQ fail after clears
        clear_scripts();
        run("R10", 1'b1, 8'h40, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);         // retrigger ignored
        run("R3", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);          // config write first

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule